// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a processor three 8-bit parallel ports (A, B and C) behind a four-location register window. A two-bit address picks port A, port B, port C or the control location. Writes to the control location with the top bit set load a mode word that fixes each port's direction and whether ports A and B run plain or strobed. Writes with the top bit clear change one port C bit at a time.

In plain mode, ports A and B and the two 4-bit halves of port C each work as an input or an output. In strobed mode, a port moves data under a handshake. Some port C pins take on the jobs of strobe or acknowledge input, buffer-full flag and interrupt request. Software polls those flags by reading port C. All pins are sampled on the block clock and are assumed to be synchronous to it. A pin is split into separate in, out and output-enable signals, and the pad ring joins them.

Top module: `ppi_core`

## Requirements
- R1: A bus write happens in a cycle with cs_n=0 and wr_n=0. A bus read happens in a cycle with cs_n=0, rd_n=0 and wr_n=1. addr 0 selects port A, 1 selects port B, 2 selects port C and 3 selects control. dout shows the read data during the read cycle and is 0 otherwise. Reading control returns 0.
- R2: After reset, every port is a plain input: pa_oe, pb_oe and pc_oe are 0. All output latches are 0, all handshake flags are clear and the port C latch is 0.
- R3: A control write with din[7]=1 is a mode word. The fields are: bit5 sets port A strobed, bit4 sets port A as input, bit3 sets port C bits 7:4 as input, bit2 sets port B strobed, bit1 sets port B as input and bit0 sets port C bits 3:0 as input. Bit6 is ignored. A mode word clears the A, B and C output latches and all handshake flags.
- R4: In plain mode, an output port drives its latch with all enables at 1. A read of an input port returns the live pins, and a read of an output port returns its latch. Each half of port C follows its own direction bit, bit by bit, for both drive and readback.
- R5: A control write with din[7]=0 sets port C latch bit din[3:1] to din[0] and leaves the other seven bits unchanged. For example, 0x09 sets bit 4 and 0x08 clears it.
- R6: In strobed input mode for port A, a clock on which PC4 is sampled low after being high does two things: it latches pa_in into the port A input register and it drives IBF high on PC5. Later reads of port A return the latched byte, not the live pins. A read of port A clears IBF.
- R7: In strobed output mode for port A, a write to port A drives OBF_n low on PC7 and drives the byte on pa_out. A falling acknowledge on PC6 releases OBF_n high.
- R8: Port B works the same way in strobed mode. PC2 is its strobe or acknowledge input. PC1 carries IBF (active high) when port B is an input and OBF_n (active low) when it is an output.
- R9: The interrupt request for port A is on PC3 and for port B on PC0. A request rises after a strobe in input mode or an acknowledge in output mode, but only while the port's enable is 1. The enable is port C latch bit 4 for port A input, bit 6 for port A output and bit 2 for port B. A read or write of that port's data address clears the request.
- R10: In strobed mode, the handshake outputs have pc_oe=1 and the handshake inputs have pc_oe=0. The remaining bits follow their half's direction. A port C read returns the live flag at each handshake output position and the enable latch bit at each handshake input position.
- R11: Flag and pin changes become visible on the cycle after the clock edge that samples the access or the pin edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench sweeps all sixteen plain-mode direction settings and predicts drive, enables and readback bit by bit. This catches a swapped port C half or a read path that returns the latch where it should return the pins. It then walks a single-bit set and clear across all eight port C positions. A wrong index decode would touch a neighbouring bit.

The strobed runs change pa_in after the strobe, so a design that reads the live pins instead of the latched byte returns the wrong value. They also check that an acknowledge releases OBF_n, and that a disabled enable keeps the interrupt low while IBF still rises. A later mode word must wipe any pending flag. A design that kept stale flags would show IBF or an interrupt after reconfiguration.

// File: rtl/ppi_pkg.sv
// Shared types for the parallel port interface.
// Assumes an 8-bit data path and a 2-bit register address.
package ppi_pkg;
    localparam int W    = 8;
    localparam int AW   = 2;
    localparam int HALF = W / 2;

    localparam logic [AW-1:0] SEL_A   = 2'd0;
    localparam logic [AW-1:0] SEL_B   = 2'd1;
    localparam logic [AW-1:0] SEL_C   = 2'd2;
    localparam logic [AW-1:0] SEL_CTL = 2'd3;

    // Decoded configuration held by the block
    typedef struct packed {
        logic a_strb;
        logic a_in;
        logic ch_in;
        logic b_strb;
        logic b_in;
        logic cl_in;
    } mode_t;

    localparam mode_t MODE_RST = '{a_strb: 1'b0, a_in: 1'b1, ch_in: 1'b1,
                                   b_strb: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    // Pull the configuration fields out of a mode word
    function automatic mode_t decode_mode(input logic [W-1:0] w);
        mode_t m;
        m.a_strb = w[5];
        m.a_in   = w[4];
        m.ch_in  = w[3];
        m.b_strb = w[2];
        m.b_in   = w[1];
        m.cl_in  = w[0];
        return m;
    endfunction
endpackage

// File: rtl/ppi_port_unit.sv
// One handshaking data port (used for A and B).
// Holds the output latch, the strobed input register, the buffer-full
// flag and the interrupt flag. Assumes hs_n is synchronous to clk.
module ppi_port_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         strobed,
    input  logic         is_input,
    input  logic         wr_hit,
    input  logic         rd_hit,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_in,
    input  logic         hs_n,
    input  logic         inte,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         intr
);
    logic         hs_prev;
    logic [W-1:0] inreg_q;
    logic         iflag_q;
    logic         hs_fall;

    assign hs_fall = hs_prev & ~hs_n;

    // Remember the last sampled handshake level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hs_prev <= 1'b1;
        else        hs_prev <= hs_n;
    end

    // Output latch, input register and handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            latch_q <= '0;
            inreg_q <= '0;
            full    <= 1'b0;
            iflag_q <= 1'b0;
        end else begin
            if (wr_hit) latch_q <= wdata;
            if (!strobed) begin
                full    <= 1'b0;
                iflag_q <= 1'b0;
            end else if (is_input) begin
                if (rd_hit || wr_hit) iflag_q <= 1'b0;
                if (hs_fall) begin
                    inreg_q <= pins_in;
                    full    <= 1'b1;
                    iflag_q <= 1'b1;
                end else if (rd_hit) begin
                    full <= 1'b0;
                end
            end else begin
                if (rd_hit || wr_hit) iflag_q <= 1'b0;
                if (wr_hit) begin
                    full <= 1'b1;
                end else if (hs_fall) begin
                    full    <= 1'b0;
                    iflag_q <= 1'b1;
                end
            end
        end
    end

    // Read path: latched byte, live pins or output latch
    always_comb begin
        if (!is_input)    rdata = latch_q;
        else if (strobed) rdata = inreg_q;
        else              rdata = pins_in;
    end

    assign intr = iflag_q & inte;
endmodule

// File: rtl/ppi_portc_mux.sv
// Builds port C drive, enables and readback from the latch, the
// direction halves and the handshake flags of ports A and B.
module ppi_portc_mux
    import ppi_pkg::*;
(
    input  mode_t        mode,
    input  logic [W-1:0] pc_latch,
    input  logic [W-1:0] pc_in,
    input  logic         full_a,
    input  logic         intr_a,
    input  logic         full_b,
    input  logic         intr_b,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe,
    output logic [W-1:0] pc_rd
);
    logic [W-1:0] base_oe;

    assign base_oe = {{HALF{~mode.ch_in}}, {HALF{~mode.cl_in}}};

    // Start from plain-mode behaviour, then overlay handshake pins
    always_comb begin
        pc_out = pc_latch;
        pc_oe  = base_oe;
        for (int i = 0; i < W; i++)
            pc_rd[i] = base_oe[i] ? pc_latch[i] : pc_in[i];
        if (mode.a_strb) begin
            pc_out[3] = intr_a; pc_oe[3] = 1'b1; pc_rd[3] = intr_a;
            if (mode.a_in) begin
                pc_out[5] = full_a; pc_oe[5] = 1'b1; pc_rd[5] = full_a;
                pc_oe[4]  = 1'b0;   pc_rd[4] = pc_latch[4];
            end else begin
                pc_out[7] = ~full_a; pc_oe[7] = 1'b1; pc_rd[7] = ~full_a;
                pc_oe[6]  = 1'b0;    pc_rd[6] = pc_latch[6];
            end
        end
        if (mode.b_strb) begin
            pc_out[0] = intr_b; pc_oe[0] = 1'b1; pc_rd[0] = intr_b;
            pc_out[1] = mode.b_in ? full_b : ~full_b;
            pc_oe[1]  = 1'b1;
            pc_rd[1]  = pc_out[1];
            pc_oe[2]  = 1'b0;   pc_rd[2] = pc_latch[2];
        end
    end
endmodule

// File: rtl/ppi_core.sv
// Top of the three-port parallel interface. Decodes the bus, holds the
// mode and port C latch, and joins the two port units and the port C
// mux. Assumes one-cycle bus strobes and pins synchronous to clk.
module ppi_core
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    input  logic [W-1:0]  pa_in,
    output logic [W-1:0]  pa_out,
    output logic [W-1:0]  pa_oe,
    input  logic [W-1:0]  pb_in,
    output logic [W-1:0]  pb_out,
    output logic [W-1:0]  pb_oe,
    input  logic [W-1:0]  pc_in,
    output logic [W-1:0]  pc_out,
    output logic [W-1:0]  pc_oe
);
    localparam int IW = $clog2(W);

    mode_t        mode_q;
    logic [W-1:0] pc_latch;
    logic         wr_hit, rd_hit, mode_wr, bsr_wr;
    logic [W-1:0] rdata_a, rdata_b, pc_rd;
    logic         full_a, intr_a, full_b, intr_b;
    logic [IW-1:0] bsr_idx;

    assign wr_hit  = ~cs_n & ~wr_n;
    assign rd_hit  = ~cs_n & ~rd_n & wr_n;
    assign mode_wr = wr_hit && addr == SEL_CTL && din[W-1];
    assign bsr_wr  = wr_hit && addr == SEL_CTL && !din[W-1];
    assign bsr_idx = din[IW:1];

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RST;
        else if (mode_wr) mode_q <= decode_mode(din);
    end

    // Port C latch: whole-byte writes and single-bit updates
    always_ff @(posedge clk) begin
        if (!rst_n || mode_wr)             pc_latch <= '0;
        else if (bsr_wr)                   pc_latch[bsr_idx] <= din[0];
        else if (wr_hit && addr == SEL_C)  pc_latch <= din;
    end

    ppi_port_unit #(.W(W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .clear(mode_wr),
        .strobed(mode_q.a_strb), .is_input(mode_q.a_in),
        .wr_hit(wr_hit && addr == SEL_A), .rd_hit(rd_hit && addr == SEL_A),
        .wdata(din), .pins_in(pa_in),
        .hs_n(mode_q.a_in ? pc_in[4] : pc_in[6]),
        .inte(mode_q.a_in ? pc_latch[4] : pc_latch[6]),
        .latch_q(pa_out), .rdata(rdata_a), .full(full_a), .intr(intr_a)
    );

    ppi_port_unit #(.W(W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .clear(mode_wr),
        .strobed(mode_q.b_strb), .is_input(mode_q.b_in),
        .wr_hit(wr_hit && addr == SEL_B), .rd_hit(rd_hit && addr == SEL_B),
        .wdata(din), .pins_in(pb_in),
        .hs_n(pc_in[2]), .inte(pc_latch[2]),
        .latch_q(pb_out), .rdata(rdata_b), .full(full_b), .intr(intr_b)
    );

    ppi_portc_mux u_pc (
        .mode(mode_q), .pc_latch(pc_latch), .pc_in(pc_in),
        .full_a(full_a), .intr_a(intr_a), .full_b(full_b), .intr_b(intr_b),
        .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd)
    );

    assign pa_oe = {W{~mode_q.a_in}};
    assign pb_oe = {W{~mode_q.b_in}};

    // Read data multiplexer, quiet outside read cycles
    always_comb begin
        dout = '0;
        if (rd_hit) begin
            case (addr)
                SEL_A:   dout = rdata_a;
                SEL_B:   dout = rdata_b;
                SEL_C:   dout = pc_rd;
                default: dout = '0;
            endcase
        end
    end
endmodule

// File: rtl/ppi_core_chk.sv
// Property checker for ppi_core, attached by bind below.
module ppi_core_chk
    import ppi_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         rd_n,
    input logic         wr_n,
    input logic [1:0]   addr,
    input logic [7:0]   din,
    input logic [7:0]   pc_in,
    input logic [7:0]   pc_out,
    input logic [7:0]   pc_oe,
    input mode_t        mode,
    input logic [7:0]   pc_latch
);
    logic wr_a, rd_a, ctl_wr;
    assign wr_a   = !cs_n && !wr_n && addr == 2'd0;
    assign rd_a   = !cs_n && !rd_n && wr_n && addr == 2'd0;
    assign ctl_wr = !cs_n && !wr_n && addr == 2'd3;

    p_obf_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.a_strb && !mode.a_in && wr_a) |=> !pc_out[7]);

    p_ibf_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.a_strb && mode.a_in && !ctl_wr && !pc_in[4] && $past(pc_in[4]))
        |=> pc_out[5]);

    p_read_clears_ibf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.a_strb && mode.a_in && rd_a && pc_in[4]) |=> !pc_out[5]);

    p_intr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.a_strb && mode.a_in && pc_out[3]) |-> pc_out[5]);

    p_hs_pin_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode.a_strb |-> (pc_oe[3] && (mode.a_in ? (pc_oe[5] && !pc_oe[4])
                                                 : (pc_oe[7] && !pc_oe[6]))));

    p_bit_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !din[7]) |=> pc_latch[$past(din[3:1])] == $past(din[0]));
endmodule

bind ppi_core ppi_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .mode(mode_q), .pc_latch(pc_latch)
);

// File: tb/tb_ppi_core.sv
// Self-checking bench: plain-mode sweep, single-bit sweep, strobed runs.
module tb_ppi_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ppi_core dut (.*);

    // Compare one value and count it
    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One-cycle bus write
    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    // One-cycle bus read, data captured mid-cycle
    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
        #2 d = dout;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    // Low pulse of one clock on a port C pin
    task automatic pulse(input int idx);
        @(negedge clk); pc_in[idx] = 1'b0;
        @(negedge clk); pc_in[idx] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R11 watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, expc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pb_oe", pb_oe, 8'h00);
        chk("R2 pc_oe", pc_oe, 8'h00);
        pa_in = 8'h6B;
        brd(2'd0, d); chk("R2 R1 read A pins", d, 8'h6B);
        brd(2'd3, d); chk("R1 control read", d, 8'h00);
        chk("R1 dout idle", dout, 8'h00);

        // R4 plain-mode sweep over all direction settings
        for (int m = 0; m < 16; m++) begin
            logic ai, ch, bi, cl;
            logic [7:0] ec;
            ai = m[3]; ch = m[2]; bi = m[1]; cl = m[0];
            bwr(2'd3, {2'b10, 1'b0, ai, ch, 1'b0, bi, cl});
            if (m == 0) begin
                brd(2'd0, d); chk("R3 latch cleared by mode", d, 8'h00);
            end
            bwr(2'd0, 8'hA5); bwr(2'd1, 8'h3C); bwr(2'd2, 8'h96);
            pa_in = 8'h10 + 8'(m); pb_in = 8'hE0 - 8'(m); pc_in = 8'h5A ^ 8'(m);
            chk("R4 pa_oe", pa_oe, ai ? 8'h00 : 8'hFF);
            chk("R4 pb_oe", pb_oe, bi ? 8'h00 : 8'hFF);
            chk("R4 pc_oe", pc_oe, {{4{~ch}}, {4{~cl}}});
            if (!ai) chk("R4 pa_out", pa_out, 8'hA5);
            brd(2'd0, d); chk("R4 read A", d, ai ? pa_in : 8'hA5);
            brd(2'd1, d); chk("R4 read B", d, bi ? pb_in : 8'h3C);
            ec = {ch ? pc_in[7:4] : 4'h9, cl ? pc_in[3:0] : 4'h6};
            brd(2'd2, d); chk("R4 read C halves", d, ec);
        end

        // R5 single-bit set then clear across port C
        pc_in = 8'hFF;
        bwr(2'd3, 8'h80);
        expc = 8'h00;
        for (int i = 0; i < 8; i++) begin
            bwr(2'd3, {4'h0, 3'(i), 1'b1});
            expc[i] = 1'b1;
            chk("R5 set bit", pc_out, expc);
        end
        for (int i = 0; i < 8; i++) begin
            bwr(2'd3, {4'h0, 3'(i), 1'b0});
            expc[i] = 1'b0;
            chk("R5 clear bit", pc_out, expc);
        end

        // A strobed input, B strobed output (mode 0xB4)
        pc_in = 8'hFF;
        bwr(2'd3, 8'hB4);
        chk("R10 pc_oe A in B out", pc_oe, 8'hEB);
        chk("R8 OBF_n idle high", {7'b0, pc_out[1]}, 8'h01);
        bwr(2'd3, 8'h09);   // port A enable, PC4 latch
        bwr(2'd3, 8'h05);   // port B enable, PC2 latch
        pa_in = 8'hC3;
        pulse(4);
        chk("R6 IBF set", {7'b0, pc_out[5]}, 8'h01);
        chk("R9 INTR A raised", {7'b0, pc_out[3]}, 8'h01);
        pa_in = 8'h00;
        brd(2'd2, d); chk("R10 poll C", d & 8'h38, 8'h38);
        brd(2'd0, d); chk("R6 latched byte", d, 8'hC3);
        chk("R6 IBF cleared by read", {7'b0, pc_out[5]}, 8'h00);
        chk("R9 INTR A cleared by read", {7'b0, pc_out[3]}, 8'h00);
        bwr(2'd1, 8'h77);
        chk("R8 pb_out", pb_out, 8'h77);
        chk("R8 OBF_n low", {7'b0, pc_out[1]}, 8'h00);
        pulse(2);
        chk("R8 ack releases OBF_n", {7'b0, pc_out[1]}, 8'h01);
        chk("R9 INTR B raised", {7'b0, pc_out[0]}, 8'h01);
        bwr(2'd1, 8'h12);
        chk("R9 INTR B cleared by write", {7'b0, pc_out[0]}, 8'h00);
        bwr(2'd3, 8'h08);   // disable port A interrupt
        pulse(4);
        chk("R9 disabled INTR stays low", {7'b0, pc_out[3]}, 8'h00);
        chk("R6 IBF still set", {7'b0, pc_out[5]}, 8'h01);
        bwr(2'd3, 8'hB4);
        chk("R3 mode clears IBF", {7'b0, pc_out[5]}, 8'h00);
        chk("R3 mode clears OBF", {7'b0, pc_out[1]}, 8'h01);

        // A strobed output, B strobed input (mode 0xAE)
        bwr(2'd3, 8'hAE);
        chk("R10 pc_oe A out B in", pc_oe, 8'h8B);
        bwr(2'd3, 8'h0D);   // port A output enable, PC6 latch
        bwr(2'd3, 8'h05);
        bwr(2'd0, 8'h9E);
        chk("R7 pa_out", pa_out, 8'h9E);
        chk("R7 OBF_n low", {7'b0, pc_out[7]}, 8'h00);
        pulse(6);
        chk("R7 ack releases OBF_n", {7'b0, pc_out[7]}, 8'h01);
        chk("R9 INTR A output raised", {7'b0, pc_out[3]}, 8'h01);
        brd(2'd0, d);
        chk("R9 INTR A cleared by access", {7'b0, pc_out[3]}, 8'h00);
        pb_in = 8'h5D;
        pulse(2);
        chk("R8 IBF B set", {7'b0, pc_out[1]}, 8'h01);
        chk("R9 INTR B input raised", {7'b0, pc_out[0]}, 8'h01);
        pb_in = 8'hFF;
        brd(2'd1, d); chk("R8 latched B byte", d, 8'h5D);
        chk("R11 IBF B cleared next cycle", {7'b0, pc_out[1]}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule